// File: doc/BRIEF.md
# Glitch-Filtered Frequency Counter

This block measures the frequency of a waveform that arrives as a stream of 8-bit unsigned samples, one per sample clock. A code of 0x80 stands for zero volts. Each sample is compared against a fixed threshold placed a little above mid-scale, so that small ripple around zero volts cannot toggle the result. The comparison is registered and then passed through one more flip-flop. Next comes a pulse-width qualifier built as a small state machine. It counts one event for each high run that lasts at least the current minimum width, and it rejects shorter runs as glitches.

An internal gate timer counts sample-clock cycles to form the measurement window. By default the window is one second at a 60 MHz sample clock. At the end of every window the event count is copied into three byte-wide output registers and a one-cycle valid strobe is raised. The counter then starts again from zero. The minimum pulse width used in a window is chosen from the result of the window before it: narrow for fast signals and wide for slow ones. The count stops at a ceiling and does not wrap.

Top module: `glitch_freq_counter`

## Requirements
- R1: A sample counts as high only when its unsigned value is strictly greater than THRESH (default 0x88). A value equal to the threshold, such as 0x88, or any value below it is low. 0x80 is the zero-volt code.
- R2: A high run after the two-stage compare and synchronize path is counted only if it lasts at least the current minimum width in cycles. A run one cycle shorter than that width adds nothing to the result.
- R3: The minimum width is W_WIDE (default 16 cycles) after reset and in any window whose preceding result was at most MID_LIMIT.
- R4: The minimum width is W_MID (default 4 cycles) in a window whose preceding result was greater than MID_LIMIT and at most FAST_LIMIT.
- R5: The minimum width is W_NARROW (default 1 cycle) in a window whose preceding result was greater than FAST_LIMIT (default 1,000,000).
- R6: A qualifying high run adds exactly one to the count, however long it stays high.
- R7: `freq_valid` is high for exactly one cycle, once every GATE_CYCLES cycles. The first strobe comes GATE_CYCLES cycles after reset is released.
- R8: The 24-bit result is split across three bytes: bits 7:0 on `freq_lo`, bits 15:8 on `freq_mid` and bits 23:16 on `freq_hi`. All three are zero after reset and change only in the cycle that `freq_valid` is high.
- R9: The count saturates at CNT_MAX (default 0xFFFFFF) instead of wrapping.
- R10: Each window's result holds only the events of that window, because the count restarts from zero after every strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | 8 | Unsigned sample, 0x80 is zero volts |
| freq_lo | output | 8 | Result bits 7:0 |
| freq_mid | output | 8 | Result bits 15:8 |
| freq_hi | output | 8 | Result bits 23:16 |
| freq_valid | output | 1 | One-cycle strobe when a new result is loaded |

## Verification
Faults inside the block appear at the ports only one window later, at the next strobe. A wrong count, a wrong threshold or a glitch that slips through shows up as an off result at the end of the window in which it happened. A fault in width selection is subtler: it reaches the ports only in the window after the one that set the width. For that reason the stimulus sequence walks the width through wide, mid, narrow and back, and in each window it mixes pulses exactly at the width with pulses one cycle under it. A timer fault shows as a strobe that comes early, late or lasts two cycles.

// File: rtl/freq_pkg.sv
package freq_pkg;

    typedef enum logic [1:0] {
        FLT_IDLE = 2'd0,
        FLT_QUAL = 2'd1,
        FLT_HELD = 2'd2
    } flt_state_t;

    typedef enum logic [1:0] {
        ACC_COUNT = 2'd0,
        ACC_FULL  = 2'd1
    } acc_state_t;

    typedef enum logic [1:0] {
        WID_WIDE   = 2'd0,
        WID_MID    = 2'd1,
        WID_NARROW = 2'd2
    } wid_sel_t;

    localparam int RESULT_BYTES = 3;
    localparam int RESULT_W     = 8 * RESULT_BYTES;

endpackage

// File: rtl/fc_threshold_sync.sv
module fc_threshold_sync #(
    parameter int          SAMPLE_W = 8,
    parameter logic [7:0]  THRESH   = 8'h88
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                level_sync
);
    logic above_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            above_q    <= 1'b0;
            level_sync <= 1'b0;
        end else begin
            above_q    <= (sample > SAMPLE_W'(THRESH));
            level_sync <= above_q;
        end
    end
endmodule

// File: rtl/fc_pulse_filter.sv
module fc_pulse_filter
    import freq_pkg::*;
#(
    parameter int RUN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level,
    input  logic [RUN_W-1:0] min_width,
    output logic             edge_hit
);
    flt_state_t       state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             hit_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLT_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        hit_d   = 1'b0;
        unique case (state_q)
            FLT_IDLE: begin
                if (level) begin
                    if (min_width <= RUN_W'(1)) begin
                        hit_d   = 1'b1;
                        state_d = FLT_HELD;
                    end else begin
                        run_d   = RUN_W'(1);
                        state_d = FLT_QUAL;
                    end
                end
            end
            FLT_QUAL: begin
                if (!level) begin
                    state_d = FLT_IDLE;
                end else if (run_q + RUN_W'(1) >= min_width) begin
                    hit_d   = 1'b1;
                    state_d = FLT_HELD;
                end else begin
                    run_d = run_q + RUN_W'(1);
                end
            end
            FLT_HELD: begin
                if (!level) state_d = FLT_IDLE;
            end
            default: state_d = FLT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) edge_hit <= 1'b0;
        else     edge_hit <= hit_d;
    end
endmodule

// File: rtl/fc_gate_timer.sv
module fc_gate_timer #(
    parameter int GATE_CYCLES = 60_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic gate_end
);
    localparam int TW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

    logic [TW-1:0] tick_q;

    assign gate_end = (tick_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)           tick_q <= '0;
        else if (gate_end) tick_q <= '0;
        else               tick_q <= tick_q + TW'(1);
    end
endmodule

// File: rtl/fc_edge_accum.sv
module fc_edge_accum
    import freq_pkg::*;
#(
    parameter logic [RESULT_W-1:0] CNT_MAX = 24'hFFFFFF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                edge_hit,
    input  logic                gate_end,
    output logic [RESULT_W-1:0] result,
    output logic                result_valid
);
    acc_state_t          state_q, state_d;
    logic [RESULT_W-1:0] count_q, count_d, total;

    always_comb begin
        total = count_q;
        if (edge_hit && state_q == ACC_COUNT && count_q < CNT_MAX)
            total = count_q + RESULT_W'(1);
    end

    always_comb begin
        state_d = state_q;
        count_d = total;
        unique case (state_q)
            ACC_COUNT: if (total == CNT_MAX) state_d = ACC_FULL;
            ACC_FULL:  state_d = ACC_FULL;
            default:   state_d = ACC_COUNT;
        endcase
        if (gate_end) begin
            count_d = '0;
            state_d = ACC_COUNT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_COUNT;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= gate_end;
            if (gate_end) result <= total;
        end
    end
endmodule

// File: rtl/fc_width_select.sv
module fc_width_select
    import freq_pkg::*;
#(
    parameter int RUN_W      = 5,
    parameter int FAST_LIMIT = 1_000_000,
    parameter int MID_LIMIT  = 10_000,
    parameter int W_NARROW   = 1,
    parameter int W_MID      = 4,
    parameter int W_WIDE     = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [RESULT_W-1:0] last_result,
    output logic [RUN_W-1:0]    min_width
);
    wid_sel_t sel_q, sel_d;

    always_comb begin
        if (last_result > RESULT_W'(FAST_LIMIT))     sel_d = WID_NARROW;
        else if (last_result > RESULT_W'(MID_LIMIT)) sel_d = WID_MID;
        else                                         sel_d = WID_WIDE;
    end

    always_ff @(posedge clk) begin
        if (rst)       sel_q <= WID_WIDE;
        else if (load) sel_q <= sel_d;
    end

    always_comb begin
        unique case (sel_q)
            WID_NARROW: min_width = RUN_W'(W_NARROW);
            WID_MID:    min_width = RUN_W'(W_MID);
            WID_WIDE:   min_width = RUN_W'(W_WIDE);
            default:    min_width = RUN_W'(W_WIDE);
        endcase
    end
endmodule

// File: rtl/glitch_freq_counter.sv
module glitch_freq_counter
    import freq_pkg::*;
#(
    parameter int                  GATE_CYCLES = 60_000_000,
    parameter logic [7:0]          THRESH      = 8'h88,
    parameter int                  FAST_LIMIT  = 1_000_000,
    parameter int                  MID_LIMIT   = 10_000,
    parameter logic [RESULT_W-1:0] CNT_MAX     = 24'hFFFFFF,
    parameter int                  W_NARROW    = 1,
    parameter int                  W_MID       = 4,
    parameter int                  W_WIDE      = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] sample,
    output logic [7:0] freq_lo,
    output logic [7:0] freq_mid,
    output logic [7:0] freq_hi,
    output logic       freq_valid
);
    localparam int RUN_W = $clog2(W_WIDE + 1);

    logic                level_sync;
    logic                edge_hit;
    logic                gate_end;
    logic [RUN_W-1:0]    flt_width;
    logic [RESULT_W-1:0] result;
    logic [7:0]          result_bytes [RESULT_BYTES];

    fc_threshold_sync #(.SAMPLE_W(8), .THRESH(THRESH)) u_cmp (
        .clk(clk), .rst(rst), .sample(sample), .level_sync(level_sync)
    );

    fc_pulse_filter #(.RUN_W(RUN_W)) u_flt (
        .clk(clk), .rst(rst), .level(level_sync),
        .min_width(flt_width), .edge_hit(edge_hit)
    );

    fc_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
        .clk(clk), .rst(rst), .gate_end(gate_end)
    );

    fc_edge_accum #(.CNT_MAX(CNT_MAX)) u_acc (
        .clk(clk), .rst(rst), .edge_hit(edge_hit), .gate_end(gate_end),
        .result(result), .result_valid(freq_valid)
    );

    fc_width_select #(
        .RUN_W(RUN_W), .FAST_LIMIT(FAST_LIMIT), .MID_LIMIT(MID_LIMIT),
        .W_NARROW(W_NARROW), .W_MID(W_MID), .W_WIDE(W_WIDE)
    ) u_wsel (
        .clk(clk), .rst(rst), .load(freq_valid),
        .last_result(result), .min_width(flt_width)
    );

    for (genvar b = 0; b < RESULT_BYTES; b++) begin : g_bytes
        assign result_bytes[b] = result[8*b +: 8];
    end

    assign freq_lo  = result_bytes[0];
    assign freq_mid = result_bytes[1];
    assign freq_hi  = result_bytes[2];
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int          GATE_CYCLES = 60_000_000,
    parameter logic [23:0] CNT_MAX     = 24'hFFFFFF,
    parameter int          RUN_W       = 5,
    parameter int          W_NARROW    = 1,
    parameter int          W_MID       = 4,
    parameter int          W_WIDE      = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             valid,
    input logic [23:0]      result,
    input logic             edge_hit,
    input logic [RUN_W-1:0] width
);
    localparam int SW = $clog2(GATE_CYCLES + 2) + 1;
    logic [SW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)        since_q <= '0;
        else if (valid) since_q <= SW'(1);
        else            since_q <= since_q + SW'(1);
    end

    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    a_r7_gate_period: assert property (@(posedge clk) disable iff (rst)
        valid |-> (since_q == SW'(GATE_CYCLES)));

    a_r7_no_late_strobe: assert property (@(posedge clk) disable iff (rst)
        since_q <= SW'(GATE_CYCLES));

    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(result));

    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        result <= CNT_MAX);

    a_r6_one_hit_per_run: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> !edge_hit);

    a_r2_width_legal: assert property (@(posedge clk) disable iff (rst)
        (width == RUN_W'(W_NARROW)) || (width == RUN_W'(W_MID)) || (width == RUN_W'(W_WIDE)));
endmodule

bind glitch_freq_counter fc_checker #(
    .GATE_CYCLES(GATE_CYCLES), .CNT_MAX(CNT_MAX), .RUN_W(RUN_W),
    .W_NARROW(W_NARROW), .W_MID(W_MID), .W_WIDE(W_WIDE)
) u_chk (
    .clk(clk), .rst(rst), .valid(freq_valid),
    .result({freq_hi, freq_mid, freq_lo}),
    .edge_hit(edge_hit), .width(flt_width)
);

// File: tb/tb_glitch_freq_counter.sv
module tb_glitch_freq_counter;
    localparam int          GATE   = 2000;
    localparam int          FASTL  = 40;
    localparam int          MIDL   = 10;
    localparam logic [23:0] SATMAX = 24'd60;
    localparam int          MARGIN = 40;
    localparam int          NWIN   = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sample = 8'h80;
    logic [7:0] freq_lo, freq_mid, freq_hi;
    logic       freq_valid;

    int tests = 0;
    int fails = 0;
    int results_seen = 0;
    int prev_exp = 0;
    bit done = 0;

    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    glitch_freq_counter #(
        .GATE_CYCLES(GATE), .FAST_LIMIT(FASTL), .MID_LIMIT(MIDL), .CNT_MAX(SATMAX)
    ) dut (
        .clk(clk), .rst(rst), .sample(sample),
        .freq_lo(freq_lo), .freq_mid(freq_mid), .freq_hi(freq_hi),
        .freq_valid(freq_valid)
    );

    function automatic int width_for(int p);
        if (p > FASTL) return 1;
        if (p > MIDL)  return 4;
        return 16;
    endfunction

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(logic [7:0] v);
        @(negedge clk);
        sample = v;
    endtask

    task automatic drive_window(string tag, int na, int wa, int ha,
                                int nb, int wb, int hb, int gap, int lov);
        int cur_w = width_for(prev_exp);
        int expc = 0;
        int used = 0;
        for (int i = 0; i < na; i++) if (ha > 8'h88 && wa >= cur_w) expc++;
        for (int i = 0; i < nb; i++) if (hb > 8'h88 && wb >= cur_w) expc++;
        if (expc > int'(SATMAX)) expc = int'(SATMAX);
        exp_q.push_back(expc);
        tag_q.push_back(tag);
        prev_exp = expc;
        for (int i = 0; i < MARGIN; i++) begin put(8'(lov)); used++; end
        for (int i = 0; i < na; i++) begin
            for (int k = 0; k < wa; k++)  begin put(8'(ha)); used++; end
            for (int k = 0; k < gap; k++) begin put(8'(lov)); used++; end
        end
        for (int i = 0; i < nb; i++) begin
            for (int k = 0; k < wb; k++)  begin put(8'(hb)); used++; end
            for (int k = 0; k < gap; k++) begin put(8'(lov)); used++; end
        end
        while (used < GATE) begin put(8'(lov)); used++; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && freq_valid) begin
            int    exp;
            string tag;
            if (exp_q.size() == 0) begin
                check("R7 unexpected strobe", 1, 0);
            end else begin
                exp = exp_q.pop_front();
                tag = tag_q.pop_front();
                check({tag, " result"}, int'({freq_hi, freq_mid, freq_lo}), exp);
            end
            results_seen++;
            @(negedge clk);
            check("R7 strobe one cycle", int'(freq_valid), 0);
            check("R8 result held after strobe", int'({freq_hi, freq_mid, freq_lo}), exp);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset lo", int'(freq_lo), 0);
        check("R8 reset mid", int'(freq_mid), 0);
        check("R8 reset hi", int'(freq_hi), 0);
        check("R7 reset valid", int'(freq_valid), 0);
        rst = 1'b0;
        // width 16 from reset: 20-wide counted, 10-wide rejected
        drive_window("R3", 8, 20, 8'hC0, 5, 10, 8'hFF, 20, 8'h80);
        // width 16 again; exactly 16 counted, 15 rejected, 0x89 high, 0x88 low floor
        drive_window("R2", 15, 16, 8'h89, 3, 15, 8'hFF, 20, 8'h88);
        // width 4: exactly 4 counted, 3 rejected
        drive_window("R4", 20, 4, 8'h90, 10, 3, 8'hFF, 20, 8'h00);
        // width 4 again, 50 events push next width narrow
        drive_window("R10", 50, 5, 8'hA0, 0, 1, 8'hFF, 20, 8'h80);
        // width 1, 480 one-cycle pulses saturate
        drive_window("R9", 480, 1, 8'hFF, 0, 1, 8'hFF, 3, 8'h80);
        // width 1: single-cycle pulses counted; 0x88 pulses not high
        drive_window("R5", 30, 1, 8'h89, 10, 1, 8'h88, 5, 8'h80);
        // width 4: short pulses all rejected
        drive_window("R4", 5, 2, 8'hFF, 5, 3, 8'hFF, 20, 8'h80);
        // width 16 after zero: threshold-level pulses ignored
        drive_window("R1", 4, 30, 8'h88, 6, 17, 8'h89, 20, 8'h80);
        // long pulses each counted once
        drive_window("R6", 3, 600, 8'hFF, 0, 1, 8'hFF, 20, 8'h80);
        repeat (20) @(negedge clk);
        check("R7 strobe count", results_seen, NWIN);
        check("R10 all windows reported", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (40000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule